// File: doc/BRIEF.md
# DSI Video Frame Timing Sequencer

This block paces a display serial link in video mode. From a set of timing words it produces, cycle by cycle in link byte-clock units, the position of the link within the frame: which vertical region the current line belongs to and which horizontal region the current cycle lies in. On active lines it marks the first cycle of every video packet slot and of every filler (null) packet slot placed between packet slots. It also reports whether the lanes are permitted to fall back to low-power signalling in the current cycle.

Software programs the timing words while the enable input `run` is low; the block copies them on every clock edge in that state. Raising `run` starts a frame at the first line of the first non-empty vertical region, and the frame repeats until `run` falls again, which returns the block to idle on the next edge. The serialiser, the PHY and the pixel buffer sit outside this block and act on its region codes and strobes.

Top module: `dsi_vtiming_seq`

## Requirements
- R1: While `rst_n` is low, or from the first clock edge at which `run` is sampled low, every output is zero (vertical code 0 = idle). Timing inputs are captured on each edge with `run` low and ignored while `run` is high.
- R2: Vertical codes are 1 sync, 2 back porch, 3 active, 4 front porch, walked in that order and repeated. `vblank_word` holds front-porch lines in bits 9:0, back-porch lines in bits 19:10 and sync lines in bits 29:20. A blanking region of zero lines is skipped, and an active count of zero is taken as one line. The first cycle of a frame is shown after the first edge with `run` high.
- R3: Each line lasts `line_cycles` cycles (zero is taken as one). Horizontal codes are 0 sync, 1 back porch, 2 active, 3 front porch. `hblank_word` holds the back-porch length in bits 15:0 and the sync length in bits 31:16. Zero-length regions are skipped, and any region still open when the line time runs out is cut off.
- R4: In sync-event mode (`video_mode` = 1), the sync cycles are reported as back porch. Mode 0 is sync pulses; modes 2 and 3 are burst.
- R5: The horizontal active region appears only on vertical-active lines. Blanking lines go sync, back porch, then front porch for the rest of the line.
- R6: `pkt_word` holds the packet slot length in bits 15:0 (zero is taken as one cycle) and the number of chunks per line in bits 31:16 (zero means a single packet). `pkt_stb` is high for one cycle at the start of every packet slot.
- R7: A null slot of `null_cycles` cycles sits between consecutive packet slots, and `null_stb` is high on its first cycle. There are no null slots in burst mode, when the chunk count is zero or one, or when `null_cycles` is zero. The active region ends after the last packet slot.
- R8: `lp_ok` is low in the sync and active regions. On blanking lines it equals the enable of that vertical region: `lp_enable` bit 0 sync, bit 1 back porch, bit 2 front porch. On active lines it is bit 3 ANDed with bit 4 in the back porch, or with bit 5 in the front porch.
- R9: The two strobes are never high together, and both occur only in the horizontal active region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High runs frames; low captures timing and idles |
| vblank_word | input | 30 | Vertical blanking line counts |
| vactive_lines | input | 16 | Active lines per frame |
| hblank_word | input | 32 | Horizontal sync and back-porch lengths |
| line_cycles | input | 16 | Total cycles per line |
| pkt_word | input | 32 | Packet slot length and chunks per line |
| null_cycles | input | 10 | Null slot length |
| lp_enable | input | 6 | Low-power permission per region |
| video_mode | input | 2 | Sync pulses, sync events or burst |
| vreg | output | 3 | Vertical region code |
| hreg | output | 2 | Horizontal region code |
| lp_ok | output | 1 | Lanes may enter low power |
| pkt_stb | output | 1 | First cycle of a packet slot |
| null_stb | output | 1 | First cycle of a null slot |

## Verification
The region codes and both strobes come from registers. They take the new value on the first clock edge after the state that causes them, so the first frame cycle appears one edge after `run` is driven high. `lp_ok` is combinational from those registers and is valid in the same cycle. Inputs change on the falling edge and outputs are sampled on the next falling edge. A reference model indexes each sample by the number of rising edges since `run` rose, and derives the expected line, position in the line and slot offset by division. The asynchronous reset is checked one time unit after it is asserted, and the return to idle is checked one edge after `run` falls.

// File: rtl/dsi_vt_pkg.sv
`timescale 1ns/1ps
package dsi_vt_pkg;

    typedef enum logic [2:0] {
        V_IDLE  = 3'd0,
        V_SYNC  = 3'd1,
        V_BACK  = 3'd2,
        V_ACT   = 3'd3,
        V_FRONT = 3'd4
    } vreg_e;

    typedef enum logic [1:0] {
        H_SYNC  = 2'd0,
        H_BACK  = 2'd1,
        H_ACT   = 2'd2,
        H_FRONT = 2'd3
    } hreg_e;

    localparam logic [1:0] MODE_EVENT = 2'd1;

    // low-power enable bit indices
    localparam int LP_VSYNC  = 0;
    localparam int LP_VBACK  = 1;
    localparam int LP_VFRONT = 2;
    localparam int LP_VACT   = 3;
    localparam int LP_HBACK  = 4;
    localparam int LP_HFRONT = 5;
    localparam int LP_BITS   = 6;

endpackage

// File: rtl/dsi_vt_cfg.sv
`timescale 1ns/1ps
module dsi_vt_cfg
    import dsi_vt_pkg::*;
#(
    parameter int VB_W = 10,
    parameter int VA_W = 16,
    parameter int HT_W = 16,
    parameter int CH_W = 16,
    parameter int NS_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [3*VB_W-1:0]     vblank_word,
    input  logic [VA_W-1:0]       vactive_lines,
    input  logic [2*HT_W-1:0]     hblank_word,
    input  logic [HT_W-1:0]       line_cycles,
    input  logic [2*CH_W-1:0]     pkt_word,
    input  logic [NS_W-1:0]       null_cycles,
    input  logic [LP_BITS-1:0]    lp_enable,
    input  logic [1:0]            video_mode,
    output logic [VB_W-1:0]       vsync_len,
    output logic [VB_W-1:0]       vback_len,
    output logic [VB_W-1:0]       vfront_len,
    output logic [VA_W-1:0]       vact_len,
    output logic [HT_W:0]         hsync_len,
    output logic [HT_W:0]         hback_len,
    output logic [HT_W-1:0]       line_last,
    output logic [CH_W-1:0]       slot_len,
    output logic [CH_W-1:0]       chunk_cnt,
    output logic [NS_W-1:0]       gap_len,
    output logic [LP_BITS-1:0]    lp_en
);

    localparam int VFP_LSB = 0;
    localparam int VBP_LSB = VB_W;
    localparam int VSA_LSB = 2 * VB_W;
    localparam int HBP_LSB = 0;
    localparam int HSA_LSB = HT_W;
    localparam int PIX_LSB = 0;
    localparam int CHK_LSB = CH_W;

    typedef struct packed {
        logic [VB_W-1:0]    vsa;
        logic [VB_W-1:0]    vbp;
        logic [VB_W-1:0]    vfp;
        logic [VA_W-1:0]    vact;
        logic [HT_W:0]      hsa;
        logic [HT_W:0]      hbp;
        logic [HT_W-1:0]    last;
        logic [CH_W-1:0]    slot;
        logic [CH_W-1:0]    chunks;
        logic [NS_W-1:0]    gap;
        logic [LP_BITS-1:0] lp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [HT_W-1:0] hsa_raw, hbp_raw;
    logic [CH_W-1:0] pix_raw, chk_raw;
    logic            is_event, is_burst;

    assign hsa_raw  = hblank_word[HSA_LSB +: HT_W];
    assign hbp_raw  = hblank_word[HBP_LSB +: HT_W];
    assign pix_raw  = pkt_word[PIX_LSB +: CH_W];
    assign chk_raw  = pkt_word[CHK_LSB +: CH_W];
    assign is_event = (video_mode == MODE_EVENT);
    assign is_burst = video_mode[1];

    always_comb begin
        cfg_d = cfg_q;
        if (!run) begin
            cfg_d.vfp    = vblank_word[VFP_LSB +: VB_W];
            cfg_d.vbp    = vblank_word[VBP_LSB +: VB_W];
            cfg_d.vsa    = vblank_word[VSA_LSB +: VB_W];
            cfg_d.vact   = (vactive_lines == '0) ? VA_W'(1) : vactive_lines;
            cfg_d.hsa    = is_event ? '0 : {1'b0, hsa_raw};
            cfg_d.hbp    = is_event ? ({1'b0, hsa_raw} + {1'b0, hbp_raw}) : {1'b0, hbp_raw};
            cfg_d.last   = (line_cycles == '0) ? '0 : (line_cycles - HT_W'(1));
            cfg_d.slot   = (pix_raw == '0) ? CH_W'(1) : pix_raw;
            cfg_d.chunks = (chk_raw == '0) ? CH_W'(1) : chk_raw;
            cfg_d.gap    = (is_burst || chk_raw == '0) ? '0 : null_cycles;
            cfg_d.lp     = lp_enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign vsync_len  = cfg_q.vsa;
    assign vback_len  = cfg_q.vbp;
    assign vfront_len = cfg_q.vfp;
    assign vact_len   = cfg_q.vact;
    assign hsync_len  = cfg_q.hsa;
    assign hback_len  = cfg_q.hbp;
    assign line_last  = cfg_q.last;
    assign slot_len   = cfg_q.slot;
    assign chunk_cnt  = cfg_q.chunks;
    assign gap_len    = cfg_q.gap;
    assign lp_en      = cfg_q.lp;

    // R1: captured timing does not move while frames run
    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg_q));

endmodule

// File: rtl/dsi_vt_vseq.sv
`timescale 1ns/1ps
module dsi_vt_vseq
    import dsi_vt_pkg::*;
#(
    parameter int VB_W = 10,
    parameter int VA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            line_end,
    input  logic [VB_W-1:0] vsync_len,
    input  logic [VB_W-1:0] vback_len,
    input  logic [VB_W-1:0] vfront_len,
    input  logic [VA_W-1:0] vact_len,
    output logic [2:0]      vreg_now,
    output logic [2:0]      vreg_next
);

    localparam int VW = (VA_W > VB_W) ? VA_W : VB_W;

    typedef struct packed {
        vreg_e          vreg;
        logic [VW-1:0]  rem;
    } vst_t;

    localparam vst_t V_RST = '0;

    vst_t v_d, v_q;

    function automatic vst_t v_enter(vreg_e tgt, logic [VB_W-1:0] sa,
                                     logic [VB_W-1:0] bp, logic [VB_W-1:0] fp,
                                     logic [VA_W-1:0] act);
        vst_t  r;
        vreg_e t;
        t = tgt;
        if (t == V_FRONT && fp == '0) t = V_SYNC;
        if (t == V_SYNC  && sa == '0) t = V_BACK;
        if (t == V_BACK  && bp == '0) t = V_ACT;
        r.vreg = t;
        case (t)
            V_SYNC:  r.rem = VW'(sa) - VW'(1);
            V_BACK:  r.rem = VW'(bp) - VW'(1);
            V_FRONT: r.rem = VW'(fp) - VW'(1);
            default: r.rem = VW'(act) - VW'(1);
        endcase
        return r;
    endfunction

    function automatic vreg_e v_follow(vreg_e cur);
        case (cur)
            V_SYNC:  return V_BACK;
            V_BACK:  return V_ACT;
            V_ACT:   return V_FRONT;
            default: return V_SYNC;
        endcase
    endfunction

    always_comb begin
        v_d = v_q;
        if (!run) begin
            v_d = V_RST;
        end else if (v_q.vreg == V_IDLE) begin
            v_d = v_enter(V_SYNC, vsync_len, vback_len, vfront_len, vact_len);
        end else if (line_end) begin
            if (v_q.rem == '0)
                v_d = v_enter(v_follow(v_q.vreg), vsync_len, vback_len, vfront_len, vact_len);
            else
                v_d.rem = v_q.rem - VW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= V_RST;
        else        v_q <= v_d;
    end

    assign vreg_now  = v_q.vreg;
    assign vreg_next = v_d.vreg;

    // R2: back porch always hands over to active lines
    p_vorder_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.vreg == V_BACK) |=> (v_q.vreg == V_BACK || v_q.vreg == V_ACT || v_q.vreg == V_IDLE));

    // R2: vertical region only moves on a line boundary
    p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && v_q.vreg != V_IDLE && !line_end) |=> (v_q.vreg == $past(v_q.vreg) || v_q.vreg == V_IDLE));

endmodule

// File: rtl/dsi_vt_hseq.sv
`timescale 1ns/1ps
module dsi_vt_hseq
    import dsi_vt_pkg::*;
#(
    parameter int HT_W = 16,
    parameter int CH_W = 16,
    parameter int NS_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            v_busy,
    input  logic            act_next,
    input  logic [HT_W:0]   hsync_len,
    input  logic [HT_W:0]   hback_len,
    input  logic [HT_W-1:0] line_last,
    input  logic [CH_W-1:0] slot_len,
    input  logic [CH_W-1:0] chunk_cnt,
    input  logic [NS_W-1:0] gap_len,
    output logic [1:0]      hreg_now,
    output logic            line_end,
    output logic            pkt_stb,
    output logic            null_stb
);

    localparam int RW = (HT_W + 1 > CH_W) ? ((HT_W + 1 > NS_W) ? HT_W + 1 : NS_W)
                                          : ((CH_W > NS_W) ? CH_W : NS_W);

    typedef struct packed {
        logic [HT_W-1:0] pos;
        hreg_e           hreg;
        logic            act;
        logic            in_gap;
        logic [RW-1:0]   rem;
        logic [CH_W-1:0] left;
        logic            pkt_stb;
        logic            null_stb;
    } hst_t;

    localparam hst_t H_RST = '0;

    hst_t h_d, h_q;

    function automatic hst_t h_enter(hst_t base, hreg_e tgt, logic act,
                                     logic [HT_W:0] sa, logic [HT_W:0] bp,
                                     logic [CH_W-1:0] slot, logic [CH_W-1:0] chunks);
        hst_t  r;
        hreg_e t;
        r = base;
        t = tgt;
        if (t == H_SYNC && sa == '0) t = H_BACK;
        if (t == H_BACK && bp == '0) t = H_ACT;
        if (t == H_ACT  && !act)     t = H_FRONT;
        r.hreg    = t;
        r.in_gap  = 1'b0;
        r.pkt_stb = 1'b0;
        case (t)
            H_SYNC: r.rem = RW'(sa) - RW'(1);
            H_BACK: r.rem = RW'(bp) - RW'(1);
            H_ACT: begin
                r.rem     = RW'(slot) - RW'(1);
                r.left    = chunks - CH_W'(1);
                r.pkt_stb = 1'b1;
            end
            default: r.rem = '0;
        endcase
        return r;
    endfunction

    assign line_end = v_busy && (h_q.pos == line_last);

    always_comb begin
        hst_t base;
        base          = H_RST;
        base.act      = act_next;
        h_d           = h_q;
        h_d.pkt_stb   = 1'b0;
        h_d.null_stb  = 1'b0;
        if (!run) begin
            h_d = H_RST;
        end else if (!v_busy || line_end) begin
            h_d = h_enter(base, H_SYNC, act_next, hsync_len, hback_len, slot_len, chunk_cnt);
        end else begin
            h_d.pos = h_q.pos + HT_W'(1);
            case (h_q.hreg)
                H_SYNC: begin
                    if (h_q.rem == '0)
                        h_d = h_enter(h_d, H_BACK, h_q.act, hsync_len, hback_len, slot_len, chunk_cnt);
                    else
                        h_d.rem = h_q.rem - RW'(1);
                end
                H_BACK: begin
                    if (h_q.rem == '0)
                        h_d = h_enter(h_d, H_ACT, h_q.act, hsync_len, hback_len, slot_len, chunk_cnt);
                    else
                        h_d.rem = h_q.rem - RW'(1);
                end
                H_ACT: begin
                    if (h_q.rem != '0) begin
                        h_d.rem = h_q.rem - RW'(1);
                    end else if (h_q.left == '0) begin
                        h_d.hreg   = H_FRONT;
                        h_d.in_gap = 1'b0;
                    end else if (!h_q.in_gap && gap_len != '0) begin
                        h_d.in_gap   = 1'b1;
                        h_d.rem      = RW'(gap_len) - RW'(1);
                        h_d.null_stb = 1'b1;
                    end else begin
                        h_d.in_gap  = 1'b0;
                        h_d.rem     = RW'(slot_len) - RW'(1);
                        h_d.left    = h_q.left - CH_W'(1);
                        h_d.pkt_stb = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= H_RST;
        else        h_q <= h_d;
    end

    assign hreg_now = h_q.hreg;
    assign pkt_stb  = h_q.pkt_stb;
    assign null_stb = h_q.null_stb;

    // R3: position in the line never passes the programmed line end
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_busy |-> (h_q.pos <= line_last));

    // R9: strobes only fire inside the active region
    p_stb_in_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.pkt_stb || h_q.null_stb) |-> (h_q.hreg == H_ACT && v_busy));

    // R7: a null slot always follows a packet slot
    p_gap_after_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && v_busy && h_q.null_stb) |-> ($past(h_q.hreg) == H_ACT && !$past(h_q.in_gap)));

endmodule

// File: rtl/dsi_vtiming_seq.sv
`timescale 1ns/1ps
module dsi_vtiming_seq
    import dsi_vt_pkg::*;
#(
    parameter int VB_W = 10,
    parameter int VA_W = 16,
    parameter int HT_W = 16,
    parameter int CH_W = 16,
    parameter int NS_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [3*VB_W-1:0]   vblank_word,
    input  logic [VA_W-1:0]     vactive_lines,
    input  logic [2*HT_W-1:0]   hblank_word,
    input  logic [HT_W-1:0]     line_cycles,
    input  logic [2*CH_W-1:0]   pkt_word,
    input  logic [NS_W-1:0]     null_cycles,
    input  logic [LP_BITS-1:0]  lp_enable,
    input  logic [1:0]          video_mode,
    output logic [2:0]          vreg,
    output logic [1:0]          hreg,
    output logic                lp_ok,
    output logic                pkt_stb,
    output logic                null_stb
);

    logic [VB_W-1:0]    vsync_len, vback_len, vfront_len;
    logic [VA_W-1:0]    vact_len;
    logic [HT_W:0]      hsync_len, hback_len;
    logic [HT_W-1:0]    line_last;
    logic [CH_W-1:0]    slot_len, chunk_cnt;
    logic [NS_W-1:0]    gap_len;
    logic [LP_BITS-1:0] lp_en;
    logic [2:0]         vreg_now, vreg_next;
    logic [1:0]         hreg_now;
    logic               line_end, v_busy, act_next;

    dsi_vt_cfg #(.VB_W(VB_W), .VA_W(VA_W), .HT_W(HT_W), .CH_W(CH_W), .NS_W(NS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run(run),
        .vblank_word(vblank_word), .vactive_lines(vactive_lines),
        .hblank_word(hblank_word), .line_cycles(line_cycles),
        .pkt_word(pkt_word), .null_cycles(null_cycles),
        .lp_enable(lp_enable), .video_mode(video_mode),
        .vsync_len(vsync_len), .vback_len(vback_len), .vfront_len(vfront_len),
        .vact_len(vact_len), .hsync_len(hsync_len), .hback_len(hback_len),
        .line_last(line_last), .slot_len(slot_len), .chunk_cnt(chunk_cnt),
        .gap_len(gap_len), .lp_en(lp_en)
    );

    dsi_vt_vseq #(.VB_W(VB_W), .VA_W(VA_W)) u_vseq (
        .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
        .vsync_len(vsync_len), .vback_len(vback_len), .vfront_len(vfront_len),
        .vact_len(vact_len), .vreg_now(vreg_now), .vreg_next(vreg_next)
    );

    assign v_busy   = (vreg_now != V_IDLE);
    assign act_next = (vreg_next == V_ACT);

    dsi_vt_hseq #(.HT_W(HT_W), .CH_W(CH_W), .NS_W(NS_W)) u_hseq (
        .clk(clk), .rst_n(rst_n), .run(run), .v_busy(v_busy), .act_next(act_next),
        .hsync_len(hsync_len), .hback_len(hback_len), .line_last(line_last),
        .slot_len(slot_len), .chunk_cnt(chunk_cnt), .gap_len(gap_len),
        .hreg_now(hreg_now), .line_end(line_end), .pkt_stb(pkt_stb), .null_stb(null_stb)
    );

    // low-power permission from the registered region pair
    always_comb begin
        lp_ok = 1'b0;
        if (v_busy && (hreg_now == H_BACK || hreg_now == H_FRONT)) begin
            case (vreg_now)
                V_SYNC:  lp_ok = lp_en[LP_VSYNC];
                V_BACK:  lp_ok = lp_en[LP_VBACK];
                V_FRONT: lp_ok = lp_en[LP_VFRONT];
                default: lp_ok = lp_en[LP_VACT] &
                                 ((hreg_now == H_BACK) ? lp_en[LP_HBACK] : lp_en[LP_HFRONT]);
            endcase
        end
    end

    assign vreg = vreg_now;
    assign hreg = hreg_now;

    // R8: never low power while pixels or packets are on the lanes
    p_lp_off_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hreg == H_ACT || hreg == H_SYNC) |-> !lp_ok);

    // R5: horizontal active region only on vertical-active lines
    p_act_on_vact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hreg == H_ACT) |-> (vreg == V_ACT));

endmodule

// File: tb/dsi_vtiming_seq_test.sv
`timescale 1ns/1ps
module dsi_vtiming_seq_test;

    typedef struct packed {
        logic [9:0]  vsa;
        logic [9:0]  vbp;
        logic [9:0]  vfp;
        logic [15:0] vact;
        logic [15:0] hsa;
        logic [15:0] hbp;
        logic [15:0] lcyc;
        logic [15:0] pix;
        logic [15:0] chunks;
        logic [9:0]  nul;
        logic [5:0]  lp;
        logic [1:0]  mode;
        logic [15:0] cycles;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{10'd1, 10'd1, 10'd1, 16'd2, 16'd3, 16'd2, 16'd30, 16'd4, 16'd3, 10'd2, 6'b111111, 2'd0, 16'd320},
        '{10'd2, 10'd0, 10'd2, 16'd3, 16'd2, 16'd3, 16'd25, 16'd10, 16'd0, 10'd5, 6'b010101, 2'd1, 16'd200},
        '{10'd0, 10'd1, 10'd0, 16'd2, 16'd1, 16'd1, 16'd20, 16'd3, 16'd4, 10'd7, 6'b101010, 2'd2, 16'd150},
        '{10'd1, 10'd0, 10'd0, 16'd1, 16'd2, 16'd2, 16'd10, 16'd8, 16'd2, 10'd3, 6'b111000, 2'd0, 16'd60},
        '{10'd0, 10'd0, 10'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1, 10'd4, 6'b111111, 2'd0, 16'd20},
        '{10'd1, 10'd2, 10'd1, 16'd1, 16'd0, 16'd4, 16'd24, 16'd2, 16'd3, 10'd0, 6'b011011, 2'd3, 16'd120}
    };

    logic        clk = 1'b0;
    logic        rst_n, run;
    logic [29:0] vblank_word;
    logic [15:0] vactive_lines, line_cycles;
    logic [31:0] hblank_word, pkt_word;
    logic [9:0]  null_cycles;
    logic [5:0]  lp_enable;
    logic [1:0]  video_mode;
    logic [2:0]  vreg;
    logic [1:0]  hreg;
    logic        lp_ok, pkt_stb, null_stb;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    dsi_vtiming_seq uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .vblank_word(vblank_word), .vactive_lines(vactive_lines),
        .hblank_word(hblank_word), .line_cycles(line_cycles),
        .pkt_word(pkt_word), .null_cycles(null_cycles),
        .lp_enable(lp_enable), .video_mode(video_mode),
        .vreg(vreg), .hreg(hreg), .lp_ok(lp_ok), .pkt_stb(pkt_stb), .null_stb(null_stb)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic apply(input vec_t v);
        vblank_word   = {v.vsa, v.vbp, v.vfp};
        vactive_lines = v.vact;
        hblank_word   = {v.hsa, v.hbp};
        line_cycles   = v.lcyc;
        pkt_word      = {v.chunks, v.pix};
        null_cycles   = v.nul;
        lp_enable     = v.lp;
        video_mode    = v.mode;
    endtask

    task automatic scramble();
        vblank_word   = 30'h0040_1003;
        vactive_lines = 16'd9;
        hblank_word   = 32'h0001_0001;
        line_cycles   = 16'd7;
        pkt_word      = 32'h0002_0001;
        null_cycles   = 10'd1;
        lp_enable     = ~lp_enable;
        video_mode    = 2'd1;
    endtask

    // reference: index by cycles since start, derive line and offset by division
    function automatic logic [7:0] model(input vec_t v, input int t);
        int L, k, p, va, fr, r, vr, s, b, pk, n, nl, al, hr, o, sl;
        logic lp, ps, ns;
        L  = (v.lcyc == 16'd0) ? 1 : int'(v.lcyc);
        k  = t / L;
        p  = t % L;
        va = (v.vact == 16'd0) ? 1 : int'(v.vact);
        fr = int'(v.vsa) + int'(v.vbp) + va + int'(v.vfp);
        r  = k % fr;
        if (r < int'(v.vsa))                             vr = 1;
        else if (r < int'(v.vsa) + int'(v.vbp))          vr = 2;
        else if (r < int'(v.vsa) + int'(v.vbp) + va)     vr = 3;
        else                                             vr = 4;
        s  = (v.mode == 2'd1) ? 0 : int'(v.hsa);
        b  = (v.mode == 2'd1) ? int'(v.hsa) + int'(v.hbp) : int'(v.hbp);
        pk = (v.pix == 16'd0) ? 1 : int'(v.pix);
        n  = (v.chunks == 16'd0) ? 1 : int'(v.chunks);
        nl = (v.mode[1] || v.chunks == 16'd0) ? 0 : int'(v.nul);
        al = (vr == 3) ? n * pk + (n - 1) * nl : 0;
        ps = 1'b0;
        ns = 1'b0;
        if (p < s)               hr = 0;
        else if (p < s + b)      hr = 1;
        else if (p < s + b + al) begin
            hr = 2;
            o  = p - s - b;
            sl = pk + nl;
            ps = (o % sl == 0);
            ns = (nl > 0) && (o % sl == pk);
        end else                 hr = 3;
        lp = 1'b0;
        if (hr == 1 || hr == 3) begin
            case (vr)
                1:       lp = v.lp[0];
                2:       lp = v.lp[1];
                4:       lp = v.lp[2];
                default: lp = v.lp[3] & ((hr == 1) ? v.lp[4] : v.lp[5]);
            endcase
        end
        return {3'(vr), 2'(hr), lp, ps, ns};
    endfunction

    task automatic check_idle(input string tag);
        check(tag, int'({vreg, hreg, lp_ok, pkt_stb, null_stb}), 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] e;
        rst_n = 1'b0;
        run   = 1'b0;
        apply(TBL[0]);
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle with run low");

        // table walk: each vector runs frames and is compared every cycle
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v   = TBL[i];
            run = 1'b0;
            apply(v);
            @(negedge clk);
            check_idle("R1 idle before start");
            run = 1'b1;
            for (int t = 0; t < int'(v.cycles); t++) begin
                @(negedge clk);
                e = model(v, t);
                // after t==7 the inputs are scrambled; frozen config per R1
                check((t > 7) ? "R2 vreg, R1 frozen" : "R2 vreg", int'(vreg), int'(e[7:5]));
                check((e[7:5] != 3'd3) ? "R5 hreg blank line" :
                      ((v.mode == 2'd1) ? "R4 hreg events" : "R3 hreg"),
                      int'(hreg), int'(e[4:3]));
                check("R8 lp_ok", int'(lp_ok), int'(e[2]));
                check("R6 pkt_stb", int'(pkt_stb), int'(e[1]));
                check("R7 null_stb", int'(null_stb), int'(e[0]));
                check("R9 strobes exclusive", int'(pkt_stb & null_stb), 0);
                if (t == 7) scramble();
            end
        end

        run = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after run falls");

        // asynchronous reset in the middle of a frame
        apply(TBL[0]);
        @(negedge clk);
        run = 1'b1;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_idle("R1 async reset mid frame");
        @(negedge clk);
        run   = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset release");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule